// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block connects a simple valid/ready host request port to an asynchronous 16-bit parallel NOR flash bus. The host asks for one of three operations: erase a block, program a word, or read a word. Each request carries an address and a data word. For the two write-type operations the block produces the flash's two-step command protocol: a command write, then either a confirm write or a data write. For a read it produces one timed read cycle and returns the sampled word with a one-cycle valid pulse.

Every bus edge is timed by counting system clock cycles. The counts come from nanosecond parameters and the clock period. Each count is rounded up, and no count is smaller than one cycle. The data lines go out as a drive value plus an output-enable pair, for a pad cell one level up. Only the first chip-enable line is driven. The other two chip-enable lines, the word-mode select and the reset pin are held at their fixed working levels.

Top module: `nor_cmd_seq`

## Requirements
- R1: A request with op code 2 (erase) makes exactly two bus writes to the request address: first the word 0x0020, then the word 0x00D0.
- R2: A request with op code 1 (program) makes exactly two bus writes to the request address: first the word 0x0040, then the request data word.
- R3: In each bus write, the following hold before write enable rises:
  - write enable stays low for at least ceil(T_WP/T_CLK) cycles;
  - the address and the driven data stay unchanged for at least ceil(T_AS/T_CLK) and ceil(T_DS/T_CLK) cycles respectively;
  - chip enable is low while write enable is low;
  - output enable stays high.
  Each of these counts is at least one cycle.
- R4: After write enable rises, the address and the driven data stay unchanged, with chip enable low, for at least ceil(T_DH/T_CLK) cycles. The next falling edge of write enable comes at least ceil(T_DH/T_CLK)+ceil(T_REC/T_CLK) cycles after the rise.
- R5: A request with op code 0 (read) drives the address with chip enable and output enable low. The bus is sampled no earlier than ceil(T_RD/T_CLK) cycles after output enable falls. The sampled word appears on rd_data with rd_valid high for exactly one cycle.
- R6: The data drive enable is high only from the fall of write enable through the hold phase of a write. It is never high while output enable is low.
- R7: req_ready is high only when the sequencer is idle. A request presented while the sequencer is busy is ignored and causes no extra bus cycle.
- R8: A request with op code 3 is accepted and causes no bus cycle and no rd_valid pulse.
- R9: After reset and between operations, write enable, output enable and chip enable 0 are high and the data drive is off. The word-mode pin and the flash reset pin are always 1, and chip enables 2 and 1 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 no operation |
| req_addr | input | AW | Flash word address |
| req_data | input | 16 | Program data word |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Word sampled by a read |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 16 | Data value driven onto the flash bus |
| fl_dq_oe | output | 1 | Drive enable for the data pads |
| fl_dq_in | input | 16 | Data value seen at the data pads |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_ce_n | output | 3 | Chip enables; bit 0 is driven, bits 2:1 are held at 0 |
| fl_byte_n | output | 1 | Word-mode select, held at 1 |
| fl_rst_n | output | 1 | Flash reset, held at 1 |

## Verification
Random mixes of all four op codes, with random addresses and data, check that each op expands into the right write pair or read. They also separate command words from confirm and data words. Directed cases use data 0x0000 and 0xFFFF and the lowest and highest addresses. These expose bit slices that are swapped or truncated. A request held valid through a whole busy period tells apart a sequencer that really ignores it from one that queues or restarts. A flash model returns good data only once output enable has been low for the full access time, so sampling too early gives wrong read data.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_NOP   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WLOW,
    PH_WHOLD,
    PH_WREC,
    PH_RD
  } ph_e;

  localparam logic [15:0] W_ERASE_CMD  = 16'h0020;
  localparam logic [15:0] W_ERASE_CONF = 16'h00D0;
  localparam logic [15:0] W_PROG_CMD   = 16'h0040;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nor_seq_bus.sv
module nor_seq_bus
  import nor_seq_pkg::*;
#(
  parameter int AW = 23
) (
  input  ph_e           ph,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   word,
  output logic [AW-1:0] fl_addr,
  output logic [15:0]   fl_dq_out,
  output logic          fl_dq_oe,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          fl_ce0_n
);
  logic drive;

  assign drive     = (ph == PH_WLOW) || (ph == PH_WHOLD);
  assign fl_addr   = addr;
  assign fl_dq_oe  = drive;
  assign fl_dq_out = drive ? word : 16'h0000;
  assign fl_we_n   = (ph != PH_WLOW);
  assign fl_oe_n   = (ph != PH_RD);
  assign fl_ce0_n  = !(drive || (ph == PH_RD));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW       = 23,
  parameter int T_CLK_NS = 5,
  parameter int T_WP_NS  = 70,
  parameter int T_DS_NS  = 50,
  parameter int T_AS_NS  = 55,
  parameter int T_DH_NS  = 10,
  parameter int T_REC_NS = 30,
  parameter int T_RD_NS  = 120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_data,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  output logic [AW-1:0] fl_addr,
  output logic [15:0]   fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [15:0]   fl_dq_in,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [2:0]    fl_ce_n,
  output logic          fl_byte_n,
  output logic          fl_rst_n
);
  localparam int N_LOW  = max2(ns_to_cyc(T_WP_NS, T_CLK_NS),
                               max2(ns_to_cyc(T_DS_NS, T_CLK_NS), ns_to_cyc(T_AS_NS, T_CLK_NS)));
  localparam int N_HOLD = ns_to_cyc(T_DH_NS, T_CLK_NS);
  localparam int N_REC  = ns_to_cyc(T_REC_NS, T_CLK_NS);
  localparam int N_RD   = ns_to_cyc(T_RD_NS, T_CLK_NS);
  localparam int N_MAX  = max2(max2(N_LOW, N_HOLD), max2(N_REC, N_RD));
  localparam int CW     = $clog2(N_MAX + 1);

  localparam logic [CW-1:0] LD_LOW  = CW'(N_LOW - 1);
  localparam logic [CW-1:0] LD_HOLD = CW'(N_HOLD - 1);
  localparam logic [CW-1:0] LD_REC  = CW'(N_REC - 1);
  localparam logic [CW-1:0] LD_RD   = CW'(N_RD - 1);

  ph_e           ph, ph_n;
  op_e           op_q;
  logic          second;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  logic [15:0]   word_now;
  logic          t_load, t_zero;
  logic [CW-1:0] t_val;
  logic          fl_ce0_n;

  // named internal events
  logic accept, we_rise, pair_done, rd_sample;

  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign we_rise   = (ph == PH_WLOW) && t_zero;
  assign pair_done = (ph == PH_WREC) && t_zero && second;
  assign rd_sample = (ph == PH_RD) && t_zero;

  always_comb begin
    if (!second) word_now = (op_q == OP_ERASE) ? W_ERASE_CMD : W_PROG_CMD;
    else         word_now = (op_q == OP_ERASE) ? W_ERASE_CONF : data_q;
  end

  always_comb begin
    ph_n   = ph;
    t_load = 1'b0;
    t_val  = '0;
    case (ph)
      PH_IDLE: if (accept) begin
        case (op_e'(req_op))
          OP_READ:           begin ph_n = PH_RD;   t_load = 1'b1; t_val = LD_RD;  end
          OP_PROG, OP_ERASE: begin ph_n = PH_WLOW; t_load = 1'b1; t_val = LD_LOW; end
          default:           ph_n = PH_IDLE;
        endcase
      end
      PH_WLOW:  if (t_zero) begin ph_n = PH_WHOLD; t_load = 1'b1; t_val = LD_HOLD; end
      PH_WHOLD: if (t_zero) begin ph_n = PH_WREC;  t_load = 1'b1; t_val = LD_REC;  end
      PH_WREC:  if (t_zero) begin
        if (second) ph_n = PH_IDLE;
        else begin ph_n = PH_WLOW; t_load = 1'b1; t_val = LD_LOW; end
      end
      PH_RD:    if (t_zero) ph_n = PH_IDLE;
      default:  ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      op_q     <= OP_NOP;
      second   <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      ph       <= ph_n;
      rd_valid <= rd_sample;
      if (rd_sample) rd_data <= fl_dq_in;
      if (accept) begin
        op_q   <= op_e'(req_op);
        addr_q <= req_addr;
        data_q <= req_data;
        second <= 1'b0;
      end else if ((ph == PH_WREC) && t_zero && !second) begin
        second <= 1'b1;
      end
    end
  end

  nor_seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  nor_seq_bus #(.AW(AW)) u_bus (
    .ph        (ph),
    .addr      (addr_q),
    .word      (word_now),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_oe  (fl_dq_oe),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n),
    .fl_ce0_n  (fl_ce0_n)
  );

  assign fl_ce_n   = {2'b00, fl_ce0_n};
  assign fl_byte_n = 1'b1;
  assign fl_rst_n  = 1'b1;

  // ---------------- assertions ----------------
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_dq_oe && !fl_oe_n));

  a_r3_ce_with_we: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n[0] && fl_oe_n && fl_dq_oe));

  a_r4_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    we_rise |=> (fl_we_n && fl_dq_oe && !fl_ce_n[0] &&
                 fl_addr == $past(fl_addr) && fl_dq_out == $past(fl_dq_out)));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_we_n && fl_oe_n && fl_ce_n[0] && !fl_dq_oe));

  a_r5_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op != OP_NOP) |=> !req_ready);

  a_r4_pair_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |=> (req_ready && fl_ce_n[0]));
endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
  localparam int AW = 23;
  localparam int TCLK = 5;

  function automatic int cyc_b(input int ns);
    int n;
    n = 1;
    while (n * TCLK < ns) n++;
    return n;
  endfunction

  localparam int B_WP  = 70, B_DS = 50, B_AS = 55, B_DH = 10, B_REC = 30, B_RD = 120;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [15:0] req_data = 0;
  logic req_ready, rd_valid, fl_dq_oe, fl_we_n, fl_oe_n, fl_byte_n, fl_rst_n;
  logic [15:0] rd_data, fl_dq_out, fl_dq_in;
  logic [AW-1:0] fl_addr;
  logic [2:0] fl_ce_n;

  always #2.5 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .T_CLK_NS(TCLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_ce_n(fl_ce_n),
    .fl_byte_n(fl_byte_n), .fl_rst_n(fl_rst_n));

  int checks = 0, errors = 0;

  function automatic logic [15:0] pat(input logic [AW-1:0] a);
    return a[15:0] ^ {2'b00, a[AW-1:16], 7'h00} ^ 16'h3C5A;
  endfunction

  // flash read model: data valid only after the full access time
  int oe_cnt = 0;
  always @(posedge clk) oe_cnt <= (!fl_oe_n && !fl_ce_n[0]) ? oe_cnt + 1 : 0;
  assign fl_dq_in = (!fl_oe_n && oe_cnt >= cyc_b(B_RD) - 1) ? pat(fl_addr) : 16'hBAD0;

  // bus monitor, sampling at the falling edge
  logic [AW-1:0] log_a [0:7];
  logic [15:0]   log_d [0:7];
  int log_n = 0;
  logic prev_we = 1;
  int wl = 0, a_run = 0, d_run = 0, gap = 0, hold_left = 0;
  logic [AW-1:0] last_a = 0, cap_a = 0;
  logic [15:0] last_d = 0, cap_d = 0;
  logic seen_rise = 0;

  always @(negedge clk) if (rst_n) begin
    if (fl_dq_oe && !fl_oe_n) begin
      errors++; $display("FAIL R6: dq_oe=%0b oe_n=%0b expected no overlap", fl_dq_oe, fl_oe_n);
    end
    if (!fl_we_n && !prev_we == 0) begin  // we falls
      if (seen_rise && log_n > 0) begin
        checks++;
        if (gap < cyc_b(B_DH) + cyc_b(B_REC)) begin
          errors++; $display("FAIL R4: rise-to-fall gap %0d expected >= %0d", gap, cyc_b(B_DH) + cyc_b(B_REC));
        end
      end
      if (fl_ce_n[0] || !fl_oe_n) begin
        errors++; $display("FAIL R3: ce_n=%0b oe_n=%0b during write, expected 0/1", fl_ce_n[0], fl_oe_n);
      end
    end
    if (fl_we_n && !prev_we) begin  // we rose
      checks++;
      if (wl < cyc_b(B_WP) || a_run < cyc_b(B_AS) || d_run < cyc_b(B_DS)) begin
        errors++;
        $display("FAIL R3: low=%0d addr_setup=%0d data_setup=%0d expected >= %0d/%0d/%0d",
                 wl, a_run, d_run, cyc_b(B_WP), cyc_b(B_AS), cyc_b(B_DS));
      end
      cap_a = last_a; cap_d = last_d;
      if (log_n < 8) begin log_a[log_n] = cap_a; log_d[log_n] = cap_d; end
      log_n++;
      hold_left = cyc_b(B_DH);
      gap = 0; seen_rise = 1;
    end
    if (hold_left > 0) begin
      checks++;
      if (fl_addr != cap_a || !fl_dq_oe || fl_dq_out != cap_d || fl_ce_n[0]) begin
        errors++; $display("FAIL R4: hold addr=%h dq=%h oe=%0b expected addr=%h dq=%h oe=1",
                           fl_addr, fl_dq_out, fl_dq_oe, cap_a, cap_d);
      end
      hold_left--;
    end
    if (fl_we_n) gap++;
    wl    = fl_we_n ? 0 : wl + 1;
    a_run = fl_ce_n[0] ? 0 : ((fl_addr == last_a && a_run > 0) ? a_run + 1 : 1);
    d_run = !fl_dq_oe ? 0 : ((fl_dq_out == last_d && d_run > 0) ? d_run + 1 : 1);
    last_a = fl_addr; last_d = fl_dq_out;
    prev_we = fl_we_n;
  end

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s", msg); end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d,
                       input bit hold_busy);
    logic [15:0] got;
    int n;
    bit got_rv;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    log_n = 0; seen_rise = 0;
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    if (op != 2'd3) chk(!req_ready, $sformatf("R7: ready=%0b after accept expected 0", req_ready));
    if (hold_busy) begin
      req_op = 2'd2; req_addr = ~a;
      repeat (10) @(negedge clk);
      chk(!req_ready, "R7: ready high while busy, expected 0");
    end
    req_valid = 0;
    got_rv = 0; got = 0; n = 0;
    while (!req_ready && n < 1000) begin
      if (rd_valid) begin got_rv = 1; got = rd_data; end
      @(negedge clk); n++;
    end
    if (rd_valid) begin got_rv = 1; got = rd_data; end
    if (rd_valid) begin
      @(negedge clk);
      chk(!rd_valid, "R5: rd_valid longer than one cycle, expected 1 cycle");
    end
    repeat (2) @(negedge clk);
    case (op)
      2'd2: begin
        chk(log_n == 2, $sformatf("R1: %0d writes expected 2", log_n));
        if (log_n == 2)
          chk(log_a[0] == a && log_a[1] == a && log_d[0] == 16'h0020 && log_d[1] == 16'h00D0,
              $sformatf("R1: got %h:%h %h:%h expected %h:0020 %h:00D0", log_a[0], log_d[0], log_a[1], log_d[1], a, a));
      end
      2'd1: begin
        chk(log_n == 2, $sformatf("R2: %0d writes expected 2", log_n));
        if (log_n == 2)
          chk(log_a[0] == a && log_a[1] == a && log_d[0] == 16'h0040 && log_d[1] == d,
              $sformatf("R2: got %h:%h %h:%h expected %h:0040 %h:%h", log_a[0], log_d[0], log_a[1], log_d[1], a, a, d));
      end
      2'd0: begin
        chk(log_n == 0, $sformatf("R5: %0d writes during read expected 0", log_n));
        chk(got_rv && got == pat(a), $sformatf("R5: rd_data=%h valid=%0b expected %h", got, got_rv, pat(a)));
      end
      default: begin
        chk(log_n == 0 && !got_rv, $sformatf("R8: writes=%0d rd_valid=%0b expected 0/0", log_n, got_rv));
      end
    endcase
    chk(fl_we_n && fl_oe_n && fl_ce_n[0] && !fl_dq_oe,
        $sformatf("R9: idle strobes we=%0b oe=%0b ce=%0b dqoe=%0b expected 1/1/1/0", fl_we_n, fl_oe_n, fl_ce_n[0], fl_dq_oe));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(fl_we_n && fl_oe_n && fl_ce_n == 3'b001 && !fl_dq_oe && fl_byte_n && fl_rst_n,
        $sformatf("R9: reset pins we=%0b oe=%0b ce=%b dqoe=%0b byte=%0b rst=%0b expected 1/1/001/0/1/1",
                  fl_we_n, fl_oe_n, fl_ce_n, fl_dq_oe, fl_byte_n, fl_rst_n));
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R7: ready=0 after reset, expected 1");
    // directed corners
    do_op(2'd2, 23'h010000, 16'h0000, 0);          // R1
    do_op(2'd1, 23'h000010, 16'hCAFE, 0);          // R2
    do_op(2'd1, '0, 16'h0000, 0);                  // R2 zero data
    do_op(2'd1, {AW{1'b1}}, 16'hFFFF, 0);          // R2 all ones
    do_op(2'd0, '0, 16'h0, 0);                     // R5
    do_op(2'd0, {AW{1'b1}}, 16'h0, 0);             // R5
    do_op(2'd3, 23'h123456, 16'h1111, 0);          // R8
    do_op(2'd1, 23'h0ABCDE, 16'h5A5A, 1);          // R7 busy requests ignored
    do_op(2'd0, 23'h002000, 16'h0, 1);             // R7 during read
    for (int i = 0; i < 40; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      do_op(op, AW'($urandom), 16'($urandom), 0);
    end
    chk(fl_byte_n && fl_rst_n && fl_ce_n[2:1] == 2'b00,
        $sformatf("R9: byte=%0b rst=%0b ce21=%b expected 1/1/00", fl_byte_n, fl_rst_n, fl_ce_n[2:1]));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule